// File: doc/BRIEF.md
# Power mode and wake-up controller

This block holds the 8-bit power control register of a small 8-bit microcontroller. It moves the processor between four states: running, idle, powered down, and waiting for the oscillator to settle. In idle the CPU clock is gated and the peripheral clock keeps running. In power-down the oscillator is stopped. When the block wakes from power-down it turns the oscillator back on at once and holds the CPU clock off until a settle counter runs out. The counter length depends on the oscillator type.

The block also records why the processor was reset. An asynchronous power-on reset loads one value. A brownout reset, a watchdog reset and an external reset each load values derived from it. The brownout comparator and the oscillator are analog parts and are outside this block; both appear here as digital signals. Interrupt requests come in already masked by their enables. Each request carries a priority and a flag saying whether it may wake the processor from power-down. A separate input gives the priority of the interrupt that is currently in service.

Top module: `pwr_mode_ctl`

## Requirements
- R1: While `por_n` is low, and after it is released, the register reads 30h (bit 5 brownout flag = 1, bit 4 power-on flag = 1) and the CPU clock, peripheral clock and oscillator enables are all high.
- R2: In the run state, a write with bit 0 = 1 and bit 1 = 0 enters idle after that clock edge. Bit 0 reads 1, the CPU clock enable is low, and the peripheral clock and oscillator enables stay high.
- R3: In idle, any bit of `irq_req_i` that is high at a clock edge returns the block to run after that edge, and bit 0 reads 0.
- R4: A write in the run state with bit 1 = 1 enters power-down, and all three enables go low. If bit 0 is also 1 in the same write, power-down wins and bit 0 reads 0.
- R5: In power-down, a request line wakes the block only when its `irq_wake_i` bit is 1 and its priority is one of two cases: there is no interrupt in service (`act_vld_i` = 0), or its priority is strictly greater, as an unsigned number, than `act_pri_i`. Line i takes its priority from bits [i*PRI_W +: PRI_W] of `irq_pri_i`.
- R6: After a wake, the oscillator enable is high from the next edge on, while the CPU and peripheral clock enables stay low for exactly 1024 cycles when `osc_xtal_i` = 1, or 256 cycles when it is 0. When the CPU clock enable returns, bit 1 reads 0.
- R7: With brownout enabled and in reset mode (`bo_irq_mode_i` = 0), a high `bo_cmp_i` drives `sys_rst_o` high in the same cycle. The register then holds bit 5 = 1, bits 7, 6, 3, 2, 1, 0 = 0 and bit 4 unchanged, and the block is in run.
- R8: With brownout enabled and in interrupt mode (`bo_irq_mode_i` = 1), a high `bo_cmp_i` drives `bo_irq_o` high and leaves `sys_rst_o` low, and bit 5 is set at the next edge. This hardware set overrides a software write that clears bit 5 in the same cycle.
- R9: `bo_dis_i` = 1 stops `bo_cmp_i` from causing either a reset or an interrupt. `bo_thr_high_o` is the inverse of `bo_thr_low_cfg_i`: a configuration value of 1 selects the low threshold.
- R10: `ext_rst_i` or `wdt_rst_i` drives `sys_rst_o` high in any state, including power-down. At the next edge the block is back in run with all enables high. Bits 7, 6, 3, 2, 1 and 0 are cleared, and bits 5 and 4 are kept.
- R11: In run, a write stores bits 7, 6, 3 and 2 as written and they have no effect on the clock enables. Writing 0 to bit 5 or bit 4 clears that flag.
- R12: Register writes are ignored in every state other than run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| ext_rst_i | input | 1 | External reset request, synchronous |
| wdt_rst_i | input | 1 | Watchdog reset request, synchronous |
| sfr_we_i | input | 1 | Register write strobe |
| sfr_wdata_i | input | 8 | Register write data |
| sfr_rdata_o | output | 8 | Register read value |
| bo_cmp_i | input | 1 | Brownout comparator output, high when below threshold |
| bo_dis_i | input | 1 | Brownout detection disable |
| bo_irq_mode_i | input | 1 | 1: brownout raises an interrupt, 0: brownout resets |
| bo_thr_low_cfg_i | input | 1 | Threshold configuration bit, 1 selects the low threshold |
| bo_thr_high_o | output | 1 | High threshold select sent to the comparator |
| bo_irq_o | output | 1 | Brownout interrupt request |
| osc_xtal_i | input | 1 | 1: crystal oscillator, 0: RC or external clock |
| irq_req_i | input | NIRQ | Enabled interrupt requests |
| irq_wake_i | input | NIRQ | Per-line power-down wake capability |
| irq_pri_i | input | NIRQ*PRI_W | Per-line priorities, packed |
| act_vld_i | input | 1 | An interrupt is currently in service |
| act_pri_i | input | PRI_W | Priority of the interrupt in service |
| sys_rst_o | output | 1 | System reset from brownout, watchdog or external source |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| osc_en_o | output | 1 | Oscillator enable |

## Verification
Two things can land on the same clock edge: a software write to the register and a hardware update of the brownout flag. The bench provokes this by raising the comparator in interrupt mode on the very cycle it writes 00h. It then reads the register back and expects bit 5 set, with every other bit showing what was written. A second collision is a single write that sets both the idle bit and the power-down bit. That case is judged by the enables and the read value: the oscillator must be off and bit 0 must read 0.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_IDLE   = 2'd1,
        ST_PDOWN  = 2'd2,
        ST_SETTLE = 2'd3
    } pmc_state_e;

    // Register layout, most significant bit first.
    typedef struct packed {
        logic baud2;   // bit 7: serial baud doubler
        logic sersel;  // bit 6: serial control bit-7 function select
        logic bof;     // bit 5: brownout flag
        logic pof;     // bit 4: power-on flag
        logic gf1;     // bit 3: general flag
        logic gf0;     // bit 2: general flag
        logic pd;      // bit 1: power-down request
        logic idl;     // bit 0: idle request
    } pctl_t;

    localparam int B_IDL = 0;
    localparam int B_PD  = 1;

    localparam logic [7:0] PCTL_POR_VAL = 8'h30;

    // A reset other than power-on keeps the two cause flags.
    function automatic pctl_t keep_flags(input pctl_t cur);
        pctl_t r;
        r     = '0;
        r.bof = cur.bof;
        r.pof = cur.pof;
        return r;
    endfunction

endpackage

// File: rtl/pmc_wake.sv
module pmc_wake #(
    parameter int NIRQ  = 4,
    parameter int PRI_W = 2
) (
    input  logic [NIRQ-1:0]       irq_req,
    input  logic [NIRQ-1:0]       irq_wake,
    input  logic [NIRQ*PRI_W-1:0] irq_pri,
    input  logic                  act_vld,
    input  logic [PRI_W-1:0]      act_pri,
    output logic                  any_req,
    output logic                  pd_wake
);

    logic [NIRQ-1:0] hit;

    for (genvar i = 0; i < NIRQ; i++) begin : g_line
        logic [PRI_W-1:0] line_pri;
        logic             beats;
        assign line_pri = irq_pri[i*PRI_W +: PRI_W];
        assign beats    = !act_vld || (line_pri > act_pri);
        assign hit[i]   = irq_req[i] & irq_wake[i] & beats;
    end

    assign any_req = |irq_req;
    assign pd_wake = |hit;

endmodule

// File: rtl/pmc_brownout.sv
module pmc_brownout (
    input  logic cmp,
    input  logic dis,
    input  logic irq_mode,
    input  logic thr_low_cfg,
    output logic bo_rst,
    output logic bo_int,
    output logic thr_high
);

    logic det;

    assign det      = cmp & ~dis;
    assign bo_rst   = det & ~irq_mode;
    assign bo_int   = det & irq_mode;
    assign thr_high = ~thr_low_cfg;

endmodule

// File: rtl/pmc_core.sv
module pmc_core import pmc_pkg::*; #(
    parameter int SETTLE_XTAL = 1024,
    parameter int SETTLE_RC   = 256
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       sync_rst,
    input  logic       bo_rst,
    input  logic       bo_int,
    input  logic       sfr_we,
    input  logic [7:0] sfr_wdata,
    input  logic       osc_xtal,
    input  logic       any_req,
    input  logic       pd_wake,
    output pctl_t      pctl,
    output logic       cpu_clk_en,
    output logic       per_clk_en,
    output logic       osc_en
);

    localparam int SMAX = (SETTLE_XTAL > SETTLE_RC) ? SETTLE_XTAL : SETTLE_RC;
    localparam int CW   = (SMAX > 2) ? $clog2(SMAX) : 1;
    localparam logic [CW-1:0] LOAD_X = CW'(SETTLE_XTAL - 1);
    localparam logic [CW-1:0] LOAD_R = CW'(SETTLE_RC - 1);

    typedef struct packed {
        pmc_state_e    st;
        pctl_t         ctl;
        logic [CW-1:0] cnt;
    } core_t;

    core_t d, q;

    always_comb begin
        d = q;
        if (bo_rst) begin
            d.st      = ST_RUN;
            d.cnt     = '0;
            d.ctl     = keep_flags(q.ctl);
            d.ctl.bof = 1'b1;
        end else if (sync_rst) begin
            d.st  = ST_RUN;
            d.cnt = '0;
            d.ctl = keep_flags(q.ctl);
        end else begin
            case (q.st)
                ST_RUN: begin
                    if (sfr_we) begin
                        d.ctl = pctl_t'(sfr_wdata);
                        if (sfr_wdata[B_PD]) begin
                            d.ctl.idl = 1'b0;
                            d.st      = ST_PDOWN;
                        end else if (sfr_wdata[B_IDL]) begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                ST_IDLE: begin
                    if (any_req) begin
                        d.ctl.idl = 1'b0;
                        d.st      = ST_RUN;
                    end
                end
                ST_PDOWN: begin
                    if (pd_wake) begin
                        d.st  = ST_SETTLE;
                        d.cnt = osc_xtal ? LOAD_X : LOAD_R;
                    end
                end
                ST_SETTLE: begin
                    if (q.cnt == '0) begin
                        d.ctl.pd = 1'b0;
                        d.st     = ST_RUN;
                    end else begin
                        d.cnt = q.cnt - 1'b1;
                    end
                end
                default: d.st = ST_RUN;
            endcase
            if (bo_int) begin
                d.ctl.bof = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            q.st  <= ST_RUN;
            q.ctl <= pctl_t'(PCTL_POR_VAL);
            q.cnt <= '0;
        end else begin
            q <= d;
        end
    end

    assign pctl       = q.ctl;
    assign cpu_clk_en = (q.st == ST_RUN);
    assign per_clk_en = (q.st == ST_RUN) || (q.st == ST_IDLE);
    assign osc_en     = (q.st != ST_PDOWN);

endmodule

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl import pmc_pkg::*; #(
    parameter int NIRQ        = 4,
    parameter int PRI_W       = 2,
    parameter int SETTLE_XTAL = 1024,
    parameter int SETTLE_RC   = 256
) (
    input  logic                  clk,
    input  logic                  por_n,
    input  logic                  ext_rst_i,
    input  logic                  wdt_rst_i,
    input  logic                  sfr_we_i,
    input  logic [7:0]            sfr_wdata_i,
    output logic [7:0]            sfr_rdata_o,
    input  logic                  bo_cmp_i,
    input  logic                  bo_dis_i,
    input  logic                  bo_irq_mode_i,
    input  logic                  bo_thr_low_cfg_i,
    output logic                  bo_thr_high_o,
    output logic                  bo_irq_o,
    input  logic                  osc_xtal_i,
    input  logic [NIRQ-1:0]       irq_req_i,
    input  logic [NIRQ-1:0]       irq_wake_i,
    input  logic [NIRQ*PRI_W-1:0] irq_pri_i,
    input  logic                  act_vld_i,
    input  logic [PRI_W-1:0]      act_pri_i,
    output logic                  sys_rst_o,
    output logic                  cpu_clk_en_o,
    output logic                  per_clk_en_o,
    output logic                  osc_en_o
);

    logic  bo_rst, bo_int, any_req, pd_wake, sync_rst;
    pctl_t ctl;

    pmc_brownout u_bo (
        .cmp         (bo_cmp_i),
        .dis         (bo_dis_i),
        .irq_mode    (bo_irq_mode_i),
        .thr_low_cfg (bo_thr_low_cfg_i),
        .bo_rst      (bo_rst),
        .bo_int      (bo_int),
        .thr_high    (bo_thr_high_o)
    );

    pmc_wake #(.NIRQ(NIRQ), .PRI_W(PRI_W)) u_wake (
        .irq_req  (irq_req_i),
        .irq_wake (irq_wake_i),
        .irq_pri  (irq_pri_i),
        .act_vld  (act_vld_i),
        .act_pri  (act_pri_i),
        .any_req  (any_req),
        .pd_wake  (pd_wake)
    );

    assign sync_rst = ext_rst_i | wdt_rst_i;

    pmc_core #(.SETTLE_XTAL(SETTLE_XTAL), .SETTLE_RC(SETTLE_RC)) u_core (
        .clk        (clk),
        .por_n      (por_n),
        .sync_rst   (sync_rst),
        .bo_rst     (bo_rst),
        .bo_int     (bo_int),
        .sfr_we     (sfr_we_i),
        .sfr_wdata  (sfr_wdata_i),
        .osc_xtal   (osc_xtal_i),
        .any_req    (any_req),
        .pd_wake    (pd_wake),
        .pctl       (ctl),
        .cpu_clk_en (cpu_clk_en_o),
        .per_clk_en (per_clk_en_o),
        .osc_en     (osc_en_o)
    );

    assign sfr_rdata_o = ctl;
    assign bo_irq_o    = bo_int;
    assign sys_rst_o   = bo_rst | sync_rst;

endmodule

// File: rtl/pmc_checker.sv
module pmc_checker #(
    parameter int NIRQ = 4
) (
    input logic            clk,
    input logic            por_n,
    input logic            ext_rst_i,
    input logic            wdt_rst_i,
    input logic            bo_cmp_i,
    input logic            bo_dis_i,
    input logic            bo_irq_mode_i,
    input logic [NIRQ-1:0] irq_req_i,
    input logic [7:0]      sfr_rdata_o,
    input logic            bo_irq_o,
    input logic            sys_rst_o,
    input logic            cpu_clk_en_o,
    input logic            per_clk_en_o,
    input logic            osc_en_o
);

    // R4: oscillator off means every clock is off
    p_osc_off_all_off_r4: assert property (@(posedge clk) disable iff (!por_n)
        !osc_en_o |-> (!cpu_clk_en_o && !per_clk_en_o));

    // R4: the two mode bits never read 1 together
    p_mode_bits_excl_r4: assert property (@(posedge clk) disable iff (!por_n)
        !(sfr_rdata_o[0] && sfr_rdata_o[1]));

    // R6: the CPU clock runs only with oscillator and peripheral clock running
    p_cpu_needs_osc_r6: assert property (@(posedge clk) disable iff (!por_n)
        cpu_clk_en_o |-> (osc_en_o && per_clk_en_o));

    // R3: a request in idle restores the CPU clock at the next edge
    p_idle_exit_r3: assert property (@(posedge clk) disable iff (!por_n)
        (per_clk_en_o && !cpu_clk_en_o && (|irq_req_i)) |=> cpu_clk_en_o);

    // R5: with no request at all, power-down persists
    p_pd_hold_r5: assert property (@(posedge clk) disable iff (!por_n)
        (!osc_en_o && !(|irq_req_i) && !sys_rst_o) |=> !osc_en_o);

    // R7: brownout in reset mode raises the system reset at once
    p_bo_reset_r7: assert property (@(posedge clk) disable iff (!por_n)
        (bo_cmp_i && !bo_dis_i && !bo_irq_mode_i) |-> sys_rst_o);

    // R8: a brownout interrupt leaves bit 5 set
    p_bo_int_flag_r8: assert property (@(posedge clk) disable iff (!por_n)
        bo_irq_o |=> sfr_rdata_o[5]);

    // R9: disabled detection produces no brownout event
    p_bo_disabled_r9: assert property (@(posedge clk) disable iff (!por_n)
        (bo_dis_i && !ext_rst_i && !wdt_rst_i) |-> (!bo_irq_o && !sys_rst_o));

    // R10: watchdog or external reset returns to run
    p_sync_rst_run_r10: assert property (@(posedge clk) disable iff (!por_n)
        (ext_rst_i || wdt_rst_i) |=> (cpu_clk_en_o && osc_en_o));

endmodule

bind pwr_mode_ctl pmc_checker #(.NIRQ(NIRQ)) u_chk (
    .clk           (clk),
    .por_n         (por_n),
    .ext_rst_i     (ext_rst_i),
    .wdt_rst_i     (wdt_rst_i),
    .bo_cmp_i      (bo_cmp_i),
    .bo_dis_i      (bo_dis_i),
    .bo_irq_mode_i (bo_irq_mode_i),
    .irq_req_i     (irq_req_i),
    .sfr_rdata_o   (sfr_rdata_o),
    .bo_irq_o      (bo_irq_o),
    .sys_rst_o     (sys_rst_o),
    .cpu_clk_en_o  (cpu_clk_en_o),
    .per_clk_en_o  (per_clk_en_o),
    .osc_en_o      (osc_en_o)
);

// File: tb/sim_pwr_mode_ctl.sv
`timescale 1ns/1ps
module sim_pwr_mode_ctl;

    localparam int NIRQ  = 4;
    localparam int PRI_W = 2;

    logic                  clk = 1'b0;
    logic                  por_n = 1'b0;
    logic                  ext_rst_i = 1'b0, wdt_rst_i = 1'b0;
    logic                  sfr_we_i = 1'b0;
    logic [7:0]            sfr_wdata_i = 8'h00;
    logic [7:0]            sfr_rdata_o;
    logic                  bo_cmp_i = 1'b0, bo_dis_i = 1'b0, bo_irq_mode_i = 1'b0;
    logic                  bo_thr_low_cfg_i = 1'b1;
    logic                  bo_thr_high_o, bo_irq_o;
    logic                  osc_xtal_i = 1'b0;
    logic [NIRQ-1:0]       irq_req_i = '0, irq_wake_i = '0;
    logic [NIRQ*PRI_W-1:0] irq_pri_i = '0;
    logic                  act_vld_i = 1'b0;
    logic [PRI_W-1:0]      act_pri_i = '0;
    logic                  sys_rst_o, cpu_clk_en_o, per_clk_en_o, osc_en_o;

    int total = 0;
    int fails = 0;

    always #10 clk = ~clk;

    pwr_mode_ctl #(.NIRQ(NIRQ), .PRI_W(PRI_W)) u0 (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sfr_write(input logic [7:0] v);
        sfr_we_i    = 1'b1;
        sfr_wdata_i = v;
        step(1);
        sfr_we_i    = 1'b0;
    endtask

    task automatic t_por();
        step(2);
        chk("R1 value in reset", sfr_rdata_o, 8'h30);
        por_n = 1'b1;
        step(2);
        chk("R1 value after reset", sfr_rdata_o, 8'h30);
        chk("R1 enables", {cpu_clk_en_o, per_clk_en_o, osc_en_o}, 3'b111);
    endtask

    task automatic t_general();
        sfr_write(8'hCC);
        chk("R11 general bits stored, flags cleared", sfr_rdata_o, 8'hCC);
        chk("R11 no effect on enables", {cpu_clk_en_o, per_clk_en_o, osc_en_o}, 3'b111);
        sfr_write(8'h00);
        chk("R11 cleared", sfr_rdata_o, 8'h00);
    endtask

    task automatic t_idle();
        sfr_write(8'h01);
        chk("R2 idle bit", sfr_rdata_o, 8'h01);
        chk("R2 idle enables", {cpu_clk_en_o, per_clk_en_o, osc_en_o}, 3'b011);
        sfr_write(8'hC0);
        chk("R12 write ignored in idle", sfr_rdata_o, 8'h01);
        step(3);
        chk("R3 idle held without request", cpu_clk_en_o, 1'b0);
        irq_req_i = 4'b0100;
        step(1);
        irq_req_i = '0;
        chk("R3 idle exit clock", cpu_clk_en_o, 1'b1);
        chk("R3 idle bit cleared", sfr_rdata_o, 8'h00);
    endtask

    task automatic t_pd_rc();
        irq_wake_i = 4'b0011;
        irq_pri_i  = 8'h3E;   // line3=0 line2=3 line1=3 line0=2
        act_vld_i  = 1'b1;
        act_pri_i  = 2'd2;
        osc_xtal_i = 1'b0;
        sfr_write(8'h03);
        chk("R4 pd wins over idle", sfr_rdata_o, 8'h02);
        chk("R4 pd enables", {cpu_clk_en_o, per_clk_en_o, osc_en_o}, 3'b000);
        irq_req_i = 4'b0001;
        step(2);
        chk("R5 equal priority no wake", osc_en_o, 1'b0);
        irq_req_i = 4'b0100;
        step(2);
        chk("R5 not wake-capable no wake", osc_en_o, 1'b0);
        irq_req_i = 4'b0010;
        step(1);
        irq_req_i = '0;
        chk("R5 higher priority wakes", osc_en_o, 1'b1);
        chk("R6 cpu held in settle", {cpu_clk_en_o, per_clk_en_o}, 2'b00);
        step(255);
        chk("R6 rc settle last cycle", cpu_clk_en_o, 1'b0);
        step(1);
        chk("R6 rc settle done", cpu_clk_en_o, 1'b1);
        chk("R6 pd bit cleared", sfr_rdata_o, 8'h00);
    endtask

    task automatic t_pd_xtal();
        act_vld_i  = 1'b0;
        osc_xtal_i = 1'b1;
        sfr_write(8'h02);
        chk("R4 pd entered", osc_en_o, 1'b0);
        irq_req_i = 4'b0001;
        step(1);
        irq_req_i = '0;
        chk("R5 wake with nothing in service", osc_en_o, 1'b1);
        step(1023);
        chk("R6 xtal settle last cycle", cpu_clk_en_o, 1'b0);
        step(1);
        chk("R6 xtal settle done", cpu_clk_en_o, 1'b1);
        osc_xtal_i = 1'b0;
    endtask

    task automatic t_bo_int();
        bo_irq_mode_i = 1'b1;
        bo_cmp_i      = 1'b1;
        sfr_we_i      = 1'b1;
        sfr_wdata_i   = 8'h00;
        #1;
        chk("R8 interrupt raised", bo_irq_o, 1'b1);
        chk("R8 no reset", sys_rst_o, 1'b0);
        step(1);
        sfr_we_i = 1'b0;
        bo_cmp_i = 1'b0;
        chk("R8 hw set beats sw clear", sfr_rdata_o, 8'h20);
        sfr_write(8'h00);
        chk("R11 flag cleared by write", sfr_rdata_o, 8'h00);
    endtask

    task automatic t_bo_dis();
        bo_dis_i      = 1'b1;
        bo_irq_mode_i = 1'b0;
        bo_cmp_i      = 1'b1;
        #1;
        chk("R9 disabled no reset", sys_rst_o, 1'b0);
        step(1);
        chk("R9 disabled flag untouched", sfr_rdata_o, 8'h00);
        bo_irq_mode_i = 1'b1;
        #1;
        chk("R9 disabled no interrupt", bo_irq_o, 1'b0);
        bo_cmp_i = 1'b0;
        bo_dis_i = 1'b0;
        bo_irq_mode_i = 1'b0;
        bo_thr_low_cfg_i = 1'b1;
        #1;
        chk("R9 low threshold", bo_thr_high_o, 1'b0);
        bo_thr_low_cfg_i = 1'b0;
        #1;
        chk("R9 high threshold", bo_thr_high_o, 1'b1);
        step(1);
    endtask

    task automatic t_bo_rst();
        sfr_write(8'hC4);
        chk("R11 readback", sfr_rdata_o, 8'hC4);
        bo_cmp_i = 1'b1;
        #1;
        chk("R7 reset same cycle", sys_rst_o, 1'b1);
        step(1);
        bo_cmp_i = 1'b0;
        chk("R7 value after brownout reset", sfr_rdata_o, 8'h20);
        step(1);
        chk("R7 running", {cpu_clk_en_o, osc_en_o}, 2'b11);
    endtask

    task automatic t_sync_rst();
        sfr_write(8'hEA);
        chk("R4 pd with other bits", {sfr_rdata_o, osc_en_o}, {8'hEA, 1'b0});
        wdt_rst_i = 1'b1;
        #1;
        chk("R10 watchdog reset in pd", sys_rst_o, 1'b1);
        step(1);
        wdt_rst_i = 1'b0;
        chk("R10 value after watchdog", sfr_rdata_o, 8'h20);
        chk("R10 enables after watchdog", {cpu_clk_en_o, per_clk_en_o, osc_en_o}, 3'b111);
        sfr_write(8'h31);
        chk("R2 idle with flags", cpu_clk_en_o, 1'b0);
        ext_rst_i = 1'b1;
        step(1);
        ext_rst_i = 1'b0;
        chk("R10 value after external reset", sfr_rdata_o, 8'h30);
        chk("R10 run after external reset", cpu_clk_en_o, 1'b1);
    endtask

    initial begin
        fork
            begin
                t_por();
                t_general();
                t_idle();
                t_pd_rc();
                t_pd_xtal();
                t_bo_int();
                t_bo_dis();
                t_bo_rst();
                t_sync_rst();
            end
            begin
                repeat (100000) @(posedge clk);
                total++;
                fails++;
                $display("FAIL watchdog R1..: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule